// File: doc/BRIEF.md
# Banked Internal Data RAM with Bit and Stack Access

This block is a 128-byte on-chip data memory that can be reached in three ways. A byte port reads and writes any location by direct address. A working-register port selects one of eight registers inside one of four banks, chosen by a two-bit bank select. A bit port sets, clears and reads single bits inside a sixteen-byte window, which gives 128 addressable bits. All three ports reach the same storage, so a value written through one port can be read back through the others.

The block also holds an 8-bit stack pointer. A push increments the pointer and then writes at the new address. A pop returns the byte at the current pointer and then decrements it. A processor core uses the block as its internal scratchpad. Two or more write sources may be active in one cycle, and a fixed priority decides which one stores its value.

Top module: `bank_ram`

## Requirements
- R1: After reset every byte at 00h–7Fh reads 00h, the stack pointer reads 07h and the stack error flag is 0.
- R2: A byte write with `byte_we` high stores `byte_wdata` at `byte_addr` at the clock edge. `byte_rdata` always shows the byte at `byte_addr`, combinationally.
- R3: Register index n with bank select s maps to byte address {s[1:0], n[2:0]}, that is 8*s + n. `reg_rdata` shows that byte, and `reg_we` writes it.
- R4: A bit write to bit address b (0–127) replaces only bit b[2:0] of byte 20h + b[6:3] with `bit_val`. The other seven bits of that byte keep their values.
- R5: `bit_rdata` shows bit b[2:0] of byte 20h + b[6:3], combinationally.
- R6: A push (with `pop` low) increments the stack pointer by one and stores `stk_wdata` at the new pointer value. Because the pointer starts at 07h, the first push after reset stores at 08h.
- R7: While `pop` is high, `stk_rdata` shows the byte at the current pointer. A pop (with `push` low) decrements the pointer by one at the clock edge.
- R8: When several writes target the same byte in one cycle, the byte port wins over the register port, the register port wins over a push, and a push wins over a bit write.
- R9: When push and pop are requested in the same cycle, the stack pointer and the memory stay unchanged. `stk_err` is high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_we | input | 1 | Byte port write enable |
| byte_addr | input | 7 | Byte port address |
| byte_wdata | input | 8 | Byte port write data |
| byte_rdata | output | 8 | Byte at `byte_addr` |
| bank_sel | input | 2 | Working-register bank select |
| reg_idx | input | 3 | Working-register index |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected working register |
| bit_addr | input | 7 | Bit address in the bit window |
| bit_we | input | 1 | Bit write enable |
| bit_val | input | 1 | Value written to the addressed bit |
| bit_rdata | output | 1 | Addressed bit |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| stk_wdata | input | 8 | Data to push |
| stk_rdata | output | 8 | Byte at the stack pointer |
| sp | output | 8 | Stack pointer |
| stk_err | output | 1 | Push and pop were requested together in the previous cycle |

## Verification
Two pairs of functions can meet in the same cycle. The first is a byte-port write and a bit write that land in the same byte of the bit window. The second is a push and a pop requested together. The bench provokes the first pair by driving both writes to byte 25h in one cycle, with data chosen so that the two outcomes differ, and it also pairs a byte write with a register write to the same byte. It then reads the byte back and expects the value from the byte port. The bench provokes the second pair by raising push and pop together. It then expects the pointer and the byte above the pointer to be unchanged and `stk_err` to pulse for one cycle only.

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int SPW      = 8,
  parameter int BIT_BASE = 32,
  parameter int SP_INIT  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           byte_we,
  input  logic [AW-1:0]  byte_addr,
  input  logic [DW-1:0]  byte_wdata,
  output logic [DW-1:0]  byte_rdata,
  input  logic [1:0]     bank_sel,
  input  logic [2:0]     reg_idx,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [6:0]     bit_addr,
  input  logic           bit_we,
  input  logic           bit_val,
  output logic           bit_rdata,
  input  logic           push,
  input  logic           pop,
  input  logic [DW-1:0]  stk_wdata,
  output logic [DW-1:0]  stk_rdata,
  output logic [SPW-1:0] sp,
  output logic           stk_err
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] reg_addr, bit_byte, push_addr;
  logic [SPW-1:0] sp_inc;
  logic do_push, do_pop, clash;

  assign reg_addr  = AW'({bank_sel, reg_idx});
  assign bit_byte  = AW'(BIT_BASE) + AW'(bit_addr[6:3]);
  assign sp_inc    = sp + SPW'(1);
  assign push_addr = sp_inc[AW-1:0];
  assign clash     = push & pop;
  assign do_push   = push & ~pop;
  assign do_pop    = pop & ~push;

  assign byte_rdata = mem[byte_addr];
  assign reg_rdata  = mem[reg_addr];
  assign bit_rdata  = mem[bit_byte][bit_addr[2:0]];
  assign stk_rdata  = mem[sp[AW-1:0]];

  // write sources applied lowest priority first; later ones override
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (bit_we)  mem[bit_byte][bit_addr[2:0]] <= bit_val;
      if (do_push) mem[push_addr] <= stk_wdata;
      if (reg_we)  mem[reg_addr] <= reg_wdata;
      if (byte_we) mem[byte_addr] <= byte_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp      <= SPW'(SP_INIT);
      stk_err <= 1'b0;
    end else begin
      stk_err <= clash;
      if (do_push)     sp <= sp_inc;
      else if (do_pop) sp <= sp - SPW'(1);
    end
  end

  p_push_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> sp == $past(sp) + SPW'(1));

  p_push_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !byte_we && !reg_we) |=> stk_rdata == $past(stk_wdata));

  p_pop_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp == $past(sp) - SPW'(1));

  p_clash_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (stk_err && $stable(sp)));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |-> $past(push && pop));

  p_byte_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |=> mem[$past(byte_addr)] == $past(byte_wdata));

  p_reg_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !byte_we) |=> mem[$past(reg_addr)] == $past(reg_wdata));

  p_bit_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !(byte_we && byte_addr == bit_byte) && !(reg_we && reg_addr == bit_byte)
     && !(push && !pop && push_addr == bit_byte))
    |=> mem[$past(bit_byte)][$past(bit_addr[2:0])] == $past(bit_val));
endmodule

// File: tb/bank_ram_tb.sv
`timescale 1ns/1ps
module bank_ram_tb;
  logic clk = 0, rst_n = 0;
  logic byte_we = 0, reg_we = 0, bit_we = 0, bit_val = 0, push = 0, pop = 0;
  logic [6:0] byte_addr = 0, bit_addr = 0;
  logic [7:0] byte_wdata = 0, reg_wdata = 0, stk_wdata = 0;
  logic [1:0] bank_sel = 0;
  logic [2:0] reg_idx = 0;
  logic [7:0] byte_rdata, reg_rdata, stk_rdata, sp;
  logic bit_rdata, stk_err;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] mdl [128];
  logic [7:0] sp_exp;

  always #2.5 clk = ~clk;

  bank_ram u_dut (
    .clk(clk), .rst_n(rst_n),
    .byte_we(byte_we), .byte_addr(byte_addr), .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
    .bank_sel(bank_sel), .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_addr(bit_addr), .bit_we(bit_we), .bit_val(bit_val), .bit_rdata(bit_rdata),
    .push(push), .pop(pop), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
    .sp(sp), .stk_err(stk_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_byte(input logic [6:0] a, input string req);
    byte_addr = a; #1;
    chk(req, byte_rdata, mdl[a]);
  endtask

  task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); byte_we = 1; byte_addr = a; byte_wdata = d;
    @(negedge clk); byte_we = 0; mdl[a] = d;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 128; a++) rd_byte(7'(a), "R1 reset byte");
    chk("R1 reset sp", sp, 8'h07);
    chk("R1 reset err", {7'b0, stk_err}, 8'h00);
    sp_exp = 8'h07;

    // R2: full sweep of byte writes, then read back
    for (int a = 0; a < 128; a++) wr_byte(7'(a), 8'((a * 37 + 11) ^ 8'h5A));
    for (int a = 0; a < 128; a++) rd_byte(7'(a), "R2 byte readback");

    // R3: register reads in all banks, then register writes seen on byte port
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) begin
        bank_sel = 2'(b); reg_idx = 3'(n); #1;
        chk("R3 reg read", reg_rdata, mdl[b * 8 + n]);
      end
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) begin
        @(negedge clk); reg_we = 1; bank_sel = 2'(b); reg_idx = 3'(n);
        reg_wdata = 8'(8'hC0 + b * 16 + n);
        @(negedge clk); reg_we = 0;
        mdl[b * 8 + n] = 8'(8'hC0 + b * 16 + n);
      end
    for (int a = 0; a < 32; a++) rd_byte(7'(a), "R3 reg write at 8*bank+idx");

    // R4/R5: set each bit in turn over a cleared window, then clear each over a full one
    for (int a = 32; a < 48; a++) wr_byte(7'(a), 8'h00);
    for (int b = 0; b < 128; b++) begin
      @(negedge clk); bit_we = 1; bit_addr = 7'(b); bit_val = 1;
      @(negedge clk); bit_we = 0;
      mdl[32 + b / 8][b % 8] = 1'b1;
      rd_byte(7'(32 + b / 8), "R4 bit set");
      #1; chk("R5 bit read", {7'b0, bit_rdata}, 8'h01);
    end
    for (int b = 0; b < 128; b += 3) begin
      @(negedge clk); bit_we = 1; bit_addr = 7'(b); bit_val = 0;
      @(negedge clk); bit_we = 0;
      mdl[32 + b / 8][b % 8] = 1'b0;
      rd_byte(7'(32 + b / 8), "R4 bit clear");
      #1; chk("R5 bit read clear", {7'b0, bit_rdata}, 8'h00);
    end
    for (int a = 31; a < 49; a++) rd_byte(7'(a), "R4 window edges");

    // R6: pushes
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); push = 1; stk_wdata = 8'(8'hA1 + k * 17);
      @(negedge clk); push = 0;
      sp_exp = sp_exp + 1; mdl[sp_exp[6:0]] = 8'(8'hA1 + k * 17);
      chk("R6 push sp", sp, sp_exp);
      rd_byte(sp_exp[6:0], "R6 push store");
    end
    chk("R6 first push at 08h", mdl[8], 8'hA1);

    // R7: pops in reverse order
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); pop = 1; #1;
      chk("R7 pop data", stk_rdata, mdl[sp_exp[6:0]]);
      @(negedge clk); pop = 0;
      sp_exp = sp_exp - 1;
      chk("R7 pop sp", sp, sp_exp);
    end

    // R9: simultaneous push and pop
    @(negedge clk); push = 1; pop = 1; stk_wdata = 8'hEE;
    @(negedge clk); push = 0; pop = 0;
    chk("R9 err pulse", {7'b0, stk_err}, 8'h01);
    chk("R9 sp held", sp, sp_exp);
    rd_byte(7'(sp_exp + 1), "R9 mem held");
    @(negedge clk);
    chk("R9 err one cycle", {7'b0, stk_err}, 8'h00);

    // R8: byte vs bit on byte 25h (bit 40 -> byte 25h bit 0)
    wr_byte(7'h25, 8'hFF);
    @(negedge clk); byte_we = 1; byte_addr = 7'h25; byte_wdata = 8'h3C;
    bit_we = 1; bit_addr = 7'd40; bit_val = 1;
    @(negedge clk); byte_we = 0; bit_we = 0; mdl[7'h25] = 8'h3C;
    rd_byte(7'h25, "R8 byte over bit");
    // R8: byte vs register on 13h (bank 2, index 3)
    @(negedge clk); byte_we = 1; byte_addr = 7'h13; byte_wdata = 8'h77;
    reg_we = 1; bank_sel = 2'd2; reg_idx = 3'd3; reg_wdata = 8'h88;
    @(negedge clk); byte_we = 0; reg_we = 0; mdl[7'h13] = 8'h77;
    rd_byte(7'h13, "R8 byte over reg");
    // R8: register vs push on next stack slot
    @(negedge clk); push = 1; stk_wdata = 8'h44;
    bank_sel = 2'(((sp_exp + 1) >> 3) & 3); reg_idx = 3'((sp_exp + 1) & 7);
    reg_we = 1; reg_wdata = 8'h99;
    @(negedge clk); push = 0; reg_we = 0;
    sp_exp = sp_exp + 1; mdl[sp_exp[6:0]] = 8'h99;
    chk("R8 reg over push sp", sp, sp_exp);
    rd_byte(sp_exp[6:0], "R8 reg over push");

    done = 1;
    finish_run();
  end
endmodule